// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of two-word transmit descriptors held in system memory and feeds packets, one at a time, to a downstream transmitter. Software loads a pointer register made of a 1 kB-aligned table base and a descriptor index, fills in descriptors, and then pulses a transmit-enable set input. The engine reads the descriptor at the pointer through a single-word memory port. For an enabled descriptor it passes the buffer address and byte count to the transmitter with a start pulse, and then waits for the done strobe and its error flags.

When the transmitter finishes, the engine writes a status word over the descriptor's control word, which also hands the descriptor back to software. It then moves the index to the next slot, or back to slot zero, and raises an interrupt pulse if one was requested. On reaching a descriptor that is not enabled, it drops transmit-enable and waits for software to re-arm it.

Top module: `tx_ring_dma`

## Requirements
- R1: After reset the following outputs are all zero: `txen_o`, `ptr_o`, `mem_req_o`, `tx_start_o` and `irq_o`.
- R2: A pointer write loads bits 31:10 (table base) and bits 9:3 (index) from `ptr_wdata_i`, and bits 2:0 of `ptr_o` always read zero. A write is taken only while the engine is idle. A write made while a descriptor is in flight changes nothing.
- R3: Once transmit-enable is set, the engine reads the control word at `ptr_o` and then the buffer word at `ptr_o`+4. Only one memory request is outstanding at a time, and each request holds its address and direction until `mem_ack_i`.
- R4: For an enabled descriptor, `tx_addr_o` is the buffer word and `tx_len_o` is control-word bits 10:0. They are presented with a `tx_start_o` pulse that lasts one cycle.
- R5: After `tx_done_i`, the control word is overwritten as follows: bit 14 is underrun, bit 15 is attempt-limit, and bit 16 is late-collision. Late-collision is recorded only when `tx_gbit_i` is high. Every other bit, enable (bit 11) included, is written zero. The buffer word is never written.
- R6: After a descriptor completes, the index advances by one slot (8 bytes) when neither wrap condition applies.
- R7: After the slot at offset 0x3F8 completes, the index returns to 0.
- R8: When bit 12 (wrap) of the completed descriptor is set, the index returns to 0.
- R9: A fetched control word with bit 11 (enable) clear has the following effects: `txen_o` clears, no transmit starts, the index does not change, and the descriptor is not written. Setting transmit-enable again resumes at that same index.
- R10: `irq_o` pulses for one cycle per completed descriptor when control-word bit 13 and `irq_en_i` are both high, whatever the error flags were. With `irq_en_i` low, no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptr_we_i | input | 1 | Pointer register write strobe |
| ptr_wdata_i | input | 32 | Pointer register write value |
| txen_set_i | input | 1 | Set transmit-enable (more descriptors ready) |
| irq_en_i | input | 1 | Global transmit interrupt enable |
| ptr_o | output | 32 | Current descriptor pointer |
| txen_o | output | 1 | Transmit-enable state |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 32 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data (status word) |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 32 | Memory read data, valid with acknowledge |
| tx_start_o | output | 1 | Start-packet pulse to transmitter |
| tx_addr_o | output | 32 | Packet buffer address |
| tx_len_o | output | 11 | Packet byte count |
| tx_done_i | input | 1 | Packet finished strobe |
| tx_underrun_i | input | 1 | Underrun flag, valid with done |
| tx_attempt_lim_i | input | 1 | Attempt-limit flag, valid with done |
| tx_late_col_i | input | 1 | Late-collision flag, valid with done |
| tx_gbit_i | input | 1 | Transmitter running at 1000 Mbit |
| irq_o | output | 1 | Completion interrupt pulse |

## Verification
The assertions check four properties on every cycle:
- A memory request stays stable until its acknowledge arrives.
- The start and interrupt pulses each last one cycle.
- The index moves only by one slot or to zero, and the base changes only on an accepted write.
- Transmit-enable falls only right after a memory read response.

The bench scenarios are needed for the rest: the status-word encoding for every combination of error flags and link speed, the exact order of descriptors handed out, the wrap behaviour at the last slot and on the wrap flag, resuming at a disabled slot, counting interrupts against the global enable, and ignoring a pointer write made mid-packet.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DW = 32;

  // control word bit positions
  localparam int B_IE   = 13;
  localparam int B_WRAP = 12;
  localparam int B_EN   = 11;
  localparam int B_UND  = 14;
  localparam int B_ATT  = 15;
  localparam int B_LATE = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_START, ST_WAIT, ST_WR, ST_UPD
  } txr_state_e;
endpackage

// File: rtl/txr_ptr.sv
module txr_ptr #(
  parameter int AW    = 32,
  parameter int IDX_W = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam int LO  = 3;
  localparam int BLO = LO + IDX_W;

  logic [AW-1:BLO]    base_q;
  logic [IDX_W-1:0]   idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (wr_i) begin
      base_q <= wdata_i[AW-1:BLO];
      idx_q  <= wdata_i[BLO-1:LO];
    end else if (adv_i) begin
      // natural overflow of the index covers the table boundary
      idx_q <= wrap_i ? '0 : idx_q + 1'b1;
    end
  end

  assign ptr_o = {base_q, idx_q, {LO{1'b0}}};

  // R6
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_i) && !$stable(idx_q)) |->
      (idx_q == IDX_W'($past(idx_q) + 1'b1) || idx_q == '0));

  // R2
  base_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(base_q) |-> $past(wr_i));
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    ptr_i,
  input  logic             txen_set_i,
  input  logic             irq_en_i,
  output logic             idle_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             txen_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             tx_start_o,
  output logic [DW-1:0]    tx_addr_o,
  output logic [LEN_W-1:0] tx_len_o,
  input  logic             tx_done_i,
  input  logic             tx_underrun_i,
  input  logic             tx_attempt_lim_i,
  input  logic             tx_late_col_i,
  input  logic             tx_gbit_i,
  output logic             irq_o
);
  txr_state_e       st_q, st_d;
  logic             ie_q, wrap_q, txen_q, stop;
  logic [LEN_W-1:0] len_q;
  logic [DW-1:0]    buf_q;
  logic [2:0]       err_q;

  assign stop = (st_q == ST_RD0) && mem_ack_i && !mem_rdata_i[B_EN];

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (txen_q) st_d = ST_RD0;
      ST_RD0:   if (mem_ack_i) st_d = mem_rdata_i[B_EN] ? ST_RD1 : ST_IDLE;
      ST_RD1:   if (mem_ack_i) st_d = ST_START;
      ST_START: st_d = ST_WAIT;
      ST_WAIT:  if (tx_done_i) st_d = ST_WR;
      ST_WR:    if (mem_ack_i) st_d = ST_UPD;
      ST_UPD:   st_d = ST_RD0;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      txen_q <= 1'b0;
      ie_q   <= 1'b0;
      wrap_q <= 1'b0;
      len_q  <= '0;
      buf_q  <= '0;
      err_q  <= '0;
    end else begin
      st_q <= st_d;
      // a new set wins over a stop in the same cycle
      if (txen_set_i)  txen_q <= 1'b1;
      else if (stop)   txen_q <= 1'b0;
      if (st_q == ST_RD0 && mem_ack_i) begin
        ie_q   <= mem_rdata_i[B_IE];
        wrap_q <= mem_rdata_i[B_WRAP];
        len_q  <= mem_rdata_i[LEN_W-1:0];
      end
      if (st_q == ST_RD1 && mem_ack_i) buf_q <= mem_rdata_i;
      if (st_q == ST_WAIT && tx_done_i)
        err_q <= {tx_late_col_i & tx_gbit_i, tx_attempt_lim_i, tx_underrun_i};
    end
  end

  always_comb begin
    mem_wdata_o         = '0;
    mem_wdata_o[B_UND]  = err_q[0];
    mem_wdata_o[B_ATT]  = err_q[1];
    mem_wdata_o[B_LATE] = err_q[2];
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign mem_req_o  = (st_q == ST_RD0) || (st_q == ST_RD1) || (st_q == ST_WR);
  assign mem_we_o   = (st_q == ST_WR);
  assign mem_addr_o = (st_q == ST_RD1) ? (ptr_i | AW'(4)) : ptr_i;
  assign tx_start_o = (st_q == ST_START);
  assign tx_addr_o  = buf_q;
  assign tx_len_o   = len_q;
  assign adv_o      = (st_q == ST_UPD);
  assign wrap_o     = wrap_q;
  assign irq_o      = (st_q == ST_UPD) && ie_q && irq_en_i;
  assign txen_o     = txen_q;

  // R3
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  // R4
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o);

  // R10
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  // R9
  txen_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txen_o) |-> ($past(mem_ack_i) && !$past(mem_we_o)));
endmodule

// File: rtl/tx_ring_dma.sv
module tx_ring_dma
  import txr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 7,
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptr_we_i,
  input  logic [AW-1:0]    ptr_wdata_i,
  input  logic             txen_set_i,
  input  logic             irq_en_i,
  output logic [AW-1:0]    ptr_o,
  output logic             txen_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             tx_start_o,
  output logic [DW-1:0]    tx_addr_o,
  output logic [LEN_W-1:0] tx_len_o,
  input  logic             tx_done_i,
  input  logic             tx_underrun_i,
  input  logic             tx_attempt_lim_i,
  input  logic             tx_late_col_i,
  input  logic             tx_gbit_i,
  output logic             irq_o
);
  logic idle, adv, wrap;

  txr_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ptr_we_i && idle),
    .wdata_i (ptr_wdata_i),
    .adv_i   (adv),
    .wrap_i  (wrap),
    .ptr_o   (ptr_o)
  );

  txr_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .ptr_i            (ptr_o),
    .txen_set_i       (txen_set_i),
    .irq_en_i         (irq_en_i),
    .idle_o           (idle),
    .adv_o            (adv),
    .wrap_o           (wrap),
    .txen_o           (txen_o),
    .mem_req_o        (mem_req_o),
    .mem_we_o         (mem_we_o),
    .mem_addr_o       (mem_addr_o),
    .mem_wdata_o      (mem_wdata_o),
    .mem_ack_i        (mem_ack_i),
    .mem_rdata_i      (mem_rdata_i),
    .tx_start_o       (tx_start_o),
    .tx_addr_o        (tx_addr_o),
    .tx_len_o         (tx_len_o),
    .tx_done_i        (tx_done_i),
    .tx_underrun_i    (tx_underrun_i),
    .tx_attempt_lim_i (tx_attempt_lim_i),
    .tx_late_col_i    (tx_late_col_i),
    .tx_gbit_i        (tx_gbit_i),
    .irq_o            (irq_o)
  );
endmodule

// File: tb/sim_tx_ring_dma.sv
`timescale 1ns/1ps
module sim_tx_ring_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ptr_we = 1'b0, txen_set = 1'b0, irq_en = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic [31:0] ptr, mem_addr, mem_wdata, tx_addr;
  logic        txen, mem_req, mem_we, tx_start, irq;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [10:0] tx_len;
  logic        tx_done = 1'b0, und = 1'b0, att = 1'b0, late = 1'b0, gbit = 1'b0;

  always #4 clk = ~clk;

  tx_ring_dma u0 (
    .clk_i(clk), .rst_ni(rst_n), .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata),
    .txen_set_i(txen_set), .irq_en_i(irq_en), .ptr_o(ptr), .txen_o(txen),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .tx_start_o(tx_start), .tx_addr_o(tx_addr), .tx_len_o(tx_len),
    .tx_done_i(tx_done), .tx_underrun_i(und), .tx_attempt_lim_i(att),
    .tx_late_col_i(late), .tx_gbit_i(gbit), .irq_o(irq)
  );

  localparam logic [31:0] BASE = 32'h0001_2400;

  int checks = 0, errors = 0;
  int n_start = 0, irq_cnt = 0;
  int exp_seq [0:63];
  logic [31:0] mem [0:255];
  logic [31:0] buf1 [0:127];
  logic [10:0] len_lat;
  int dcnt = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int mix(input logic [31:0] a);
    return {a[9:3], a[2]};
  endfunction

  function automatic logic [31:0] stat(input logic [10:0] l);
    logic [31:0] s;
    s = '0;
    s[14] = l[0];
    s[15] = l[1];
    s[16] = l[2] & l[3];
    return s;
  endfunction

  function automatic logic [31:0] ctl(input bit ie, input bit wr, input bit en, input logic [10:0] l);
    return (32'(ie) << 13) | (32'(wr) << 12) | (32'(en) << 11) | 32'(l);
  endfunction

  // memory model: one-cycle ack after a request is seen
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      mem_ack <= 1'b1;
      if (mem_addr[31:10] != BASE[31:10]) chk(1'b0, "R3 base", mem_addr, BASE);
      if (mem_we) begin
        if (mem_addr[2]) chk(1'b0, "R5 word1 write", mem_addr, 32'h0);
        mem[mix(mem_addr)] <= mem_wdata;
      end else mem_rdata <= mem[mix(mem_addr)];
    end
  end

  // transmitter model: flags derived from the length bits
  always @(negedge clk) begin
    tx_done <= 1'b0;
    if (dcnt != 0) begin
      dcnt <= dcnt - 1;
      if (dcnt == 1) begin
        tx_done <= 1'b1;
        und  <= len_lat[0];
        att  <= len_lat[1];
        late <= len_lat[2];
        gbit <= len_lat[3];
      end
    end
    if (tx_start) begin
      // R4 descriptor order, buffer address and length
      chk(ptr[9:3] == 7'(exp_seq[n_start]), "R4 order", 32'(ptr[9:3]), 32'(exp_seq[n_start]));
      chk(tx_addr == buf1[ptr[9:3]], "R4 addr", tx_addr, buf1[ptr[9:3]]);
      chk(tx_len == mem[{ptr[9:3], 1'b0}][10:0], "R4 len", 32'(tx_len), 32'(mem[{ptr[9:3], 1'b0}][10:0]));
      n_start <= n_start + 1;
      len_lat <= tx_len;
      dcnt <= 3;
    end
  end

  always @(negedge clk) if (irq) irq_cnt <= irq_cnt + 1;

  task automatic pulse_txen();
    @(negedge clk) txen_set = 1'b1;
    @(negedge clk) txen_set = 1'b0;
  endtask

  task automatic wr_ptr(input logic [31:0] v);
    @(negedge clk) begin ptr_we = 1'b1; ptr_wdata = v; end
    @(negedge clk) ptr_we = 1'b0;
  endtask

  task automatic wait_stop();
    repeat (3) @(negedge clk);
    while (txen) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic put(input int i, input bit ie, input bit wr, input bit en, input logic [10:0] l);
    mem[2*i]   = ctl(ie, wr, en, l);
    buf1[i]    = 32'h8000_0000 + (32'(i) << 8);
    mem[2*i+1] = buf1[i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R3 act=%h exp=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 128; i++) buf1[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txen == 0, "R1 txen", 32'(txen), 0);
    chk(ptr == 0, "R1 ptr", ptr, 0);
    chk(mem_req == 0, "R1 req", 32'(mem_req), 0);
    chk(tx_start == 0, "R1 start", 32'(tx_start), 0);
    chk(irq == 0, "R1 irq", 32'(irq), 0);
    rst_n = 1'b1;

    // run 1: sweep of error flags, speed and per-descriptor interrupt
    for (int i = 0; i < 32; i++) begin
      put(i, i[4], 1'b0, 1'b1, 11'(64 + i));
      exp_seq[i] = i;
    end
    put(32, 1'b1, 1'b0, 1'b0, 11'd96);
    irq_en = 1'b1;
    wr_ptr(BASE | 32'h7);
    chk(ptr == BASE, "R2 ptr load", ptr, BASE);
    pulse_txen();
    wait_stop();
    chk(n_start == 32, "R4 count", 32'(n_start), 32);
    chk(irq_cnt == 16, "R10 irq count", 32'(irq_cnt), 16);
    for (int i = 0; i < 32; i++) begin
      chk(mem[2*i] == stat(11'(64 + i)), "R5 status", mem[2*i], stat(11'(64 + i)));
      chk(mem[2*i+1] == buf1[i], "R5 word1", mem[2*i+1], buf1[i]);
    end
    chk(ptr == (BASE | (32 << 3)), "R6 advance", ptr, BASE | (32 << 3));
    chk(mem[64] == ctl(1, 0, 0, 11'd96), "R9 untouched", mem[64], ctl(1, 0, 0, 11'd96));
    chk(txen == 0, "R9 txen clear", 32'(txen), 0);

    // run 2: re-arm at the stopped slot, global interrupt off
    n_start = 0; irq_cnt = 0;
    for (int i = 32; i < 48; i++) begin
      put(i, 1'b1, 1'b0, 1'b1, 11'(64 + i));
      exp_seq[i - 32] = i;
    end
    irq_en = 1'b0;
    pulse_txen();
    wait_stop();
    chk(n_start == 16, "R9 resume", 32'(n_start), 16);
    chk(irq_cnt == 0, "R10 global off", 32'(irq_cnt), 0);
    chk(ptr == (BASE | (48 << 3)), "R6 advance2", ptr, BASE | (48 << 3));
    for (int i = 32; i < 48; i++)
      chk(mem[2*i] == stat(11'(64 + i)), "R5 status2", mem[2*i], stat(11'(64 + i)));

    // run 3: early wrap, pointer write while busy must be ignored
    n_start = 0; irq_cnt = 0;
    put(48, 1'b0, 1'b0, 1'b1, 11'd200);
    put(49, 1'b0, 1'b0, 1'b1, 11'd201);
    put(50, 1'b1, 1'b1, 1'b1, 11'd207);
    exp_seq[0] = 48; exp_seq[1] = 49; exp_seq[2] = 50;
    irq_en = 1'b1;
    fork
      begin pulse_txen(); wait_stop(); end
      begin
        do @(negedge clk); while (!tx_start);
        wr_ptr(32'h0000_0800);
      end
    join
    chk(ptr == BASE, "R8 wrap flag / R2 busy write", ptr, BASE);
    chk(n_start == 3, "R8 count", 32'(n_start), 3);
    chk(irq_cnt == 1, "R10 irq wrap", 32'(irq_cnt), 1);
    chk(mem[100] == stat(11'd207), "R5 status3", mem[100], stat(11'd207));

    // run 4: last slot of the table
    n_start = 0; irq_cnt = 0;
    put(127, 1'b0, 1'b0, 1'b1, 11'd79);
    exp_seq[0] = 127;
    wr_ptr(BASE | 32'h3FF);
    chk(ptr == (BASE | 32'h3F8), "R2 low bits", ptr, BASE | 32'h3F8);
    pulse_txen();
    wait_stop();
    chk(n_start == 1, "R7 count", 32'(n_start), 1);
    chk(ptr == BASE, "R7 boundary wrap", ptr, BASE);
    chk(mem[254] == stat(11'd79), "R5 late gbit", mem[254], stat(11'd79));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule